// File: doc/BRIEF.md
# Byte-Serial Modulo-15 Bus Checker

This block watches a 4-bit bus on which 32-bit coded words travel as eight nibble transfers. It checks each word for code consistency while the word is still streaming, using a 4-bit accumulator that adds every arriving nibble with an end-around carry. Every numeric operand is a multiple of fifteen, so a clean word leaves the accumulator at all ones. That is the ones'-complement form of zero. The all-zero pattern is the other form of zero, and the block does not accept it, so a silent bus shows up as an error.

A word-type input is sampled with the first nibble and sets how the word is read. An operand word is summed in full. An instruction word starts with three operation-code nibbles. Each of these must have exactly two bits set, and none of them enters the accumulator. Five address nibbles follow, and only these are summed. One clock after the last nibble, the block gives its verdict on separate arithmetic and operation-code lines. The verdict holds until the next word begins. If a new word begins before the current one has all its nibbles, the block raises a truncation flag.

Top module: `mod15_bus_checker`

## Requirements
- R1: After reset, `chk_valid`, `arith_err`, `opc_err` and `short_err` are all 0.
- R2: Operand mode (`word_instr`=0 with the first nibble) sums all eight nibbles with end-around carry. One clock after the eighth accepted nibble, `chk_valid`=1, `short_err`=0, `opc_err`=0, and `arith_err`=1 exactly when the final sum is not 4'b1111. This means the nibble total is either zero or not a multiple of 15.
- R3: Instruction mode (`word_instr`=1 with the first nibble) treats the first three accepted nibbles as operation code and the last five as the address part. Only the address nibbles are summed for `arith_err`.
- R4: In instruction mode, `opc_err`=1 in the verdict if any of the three operation-code nibbles has a number of 1 bits other than two.
- R5: The accumulator starts at 4'b0000 for each word, so a summed part that is all zeros gives `arith_err`=1.
- R6: A verdict holds until a nibble arrives with `word_start`=1. On the clock after that nibble, `chk_valid` drops to 0, unless R9 applies.
- R7: Cycles with `nib_vld`=0 add no nibble and change nothing, whatever `word_start`, `word_instr` and `nib` carry.
- R8: A valid nibble that arrives with no word in progress and with `word_start`=0 is ignored.
- R9: A nibble with `word_start`=1 that arrives while a word is only partly received gives, one clock later, `chk_valid`=1, `short_err`=1, `arith_err`=0 and `opc_err`=0. That nibble is the first nibble of a new word.
- R10: `word_instr` counts only on the starting nibble. Changes to it later in the word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_start | input | 1 | Marks the first nibble of a word, qualified by nib_vld |
| nib_vld | input | 1 | A nibble is present on nib this cycle |
| word_instr | input | 1 | 1 = instruction word, 0 = operand word, taken with the first nibble |
| nib | input | 4 | Bus nibble |
| chk_valid | output | 1 | A verdict is being shown |
| arith_err | output | 1 | Modulo-15 residue check failed |
| opc_err | output | 1 | An operation-code nibble failed the two-of-four check |
| short_err | output | 1 | A word was cut short by an early start |

## Verification
A wrong nibble count puts the verdict out of step with the traffic. The verdict then appears early or late, or a word gets absorbed into the next one, and this is visible at `chk_valid` on the clock after the eighth nibble of the affected word. A corrupted accumulator or a lost carry changes `arith_err` for that word's verdict and no later one, so every word is scored as it ends. A mode bit that latches at the wrong time shows up in `opc_err` and `arith_err` together, because the nibbles get sent down the wrong path. Random words with single-bit corruptions and random idle gaps catch these faults, and directed cases cover the all-zero word, early starts and stray nibbles.

// File: rtl/mod15_bus_checker.sv
module mod15_bus_checker #(
  parameter int WORD_NIBS = 8,
  parameter int OPC_NIBS  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       word_start,
  input  logic       nib_vld,
  input  logic       word_instr,
  input  logic [3:0] nib,
  output logic       chk_valid,
  output logic       arith_err,
  output logic       opc_err,
  output logic       short_err
);
  localparam int CW = $clog2(WORD_NIBS + 1);
  localparam logic [CW-1:0] LAST_POS = CW'(WORD_NIBS - 1);
  localparam logic [CW-1:0] OPC_END  = CW'(OPC_NIBS);
  localparam logic [CW-1:0] ONE      = CW'(1);

  function automatic logic two_hot(input logic [3:0] v);
    return (v[0] + v[1] + v[2] + v[3]) == 3'd2;
  endfunction

  logic [CW-1:0] cnt;
  logic [3:0]    acc;
  logic          instr_q;
  logic          opc_bad;

  wire           first    = nib_vld && word_start;
  wire           take     = nib_vld && (word_start || cnt != '0);
  wire           is_instr = first ? word_instr : instr_q;
  wire [CW-1:0]  pos      = first ? '0 : cnt;
  wire           opc_slot = is_instr && (pos < OPC_END);
  wire [3:0]     acc_in   = first ? 4'h0 : acc;
  wire [4:0]     raw      = {1'b0, acc_in} + {1'b0, nib};
  wire [3:0]     folded   = raw[3:0] + {3'b000, raw[4]};
  wire [3:0]     acc_nx   = opc_slot ? acc_in : folded;
  wire           opc_nx   = (first ? 1'b0 : opc_bad) | (opc_slot && !two_hot(nib));
  wire           last     = take && (pos == LAST_POS);
  wire           early    = first && (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      acc       <= 4'h0;
      instr_q   <= 1'b0;
      opc_bad   <= 1'b0;
      chk_valid <= 1'b0;
      arith_err <= 1'b0;
      opc_err   <= 1'b0;
      short_err <= 1'b0;
    end else if (take) begin
      if (last) begin
        cnt       <= '0;
        chk_valid <= 1'b1;
        arith_err <= (acc_nx != 4'hF);
        opc_err   <= opc_nx;
        short_err <= 1'b0;
      end else begin
        cnt     <= pos + ONE;
        acc     <= acc_nx;
        instr_q <= is_instr;
        opc_bad <= opc_nx;
        if (first) begin
          chk_valid <= early;
          short_err <= early;
          arith_err <= 1'b0;
          opc_err   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mod15_bus_checker_sva.sv
module mod15_bus_checker_sva #(
  parameter int WORD_NIBS = 8,
  localparam int CW = $clog2(WORD_NIBS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          word_start,
  input logic          nib_vld,
  input logic          chk_valid,
  input logic          arith_err,
  input logic          opc_err,
  input logic          short_err,
  input logic [CW-1:0] cnt
);
  assert_flags_need_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arith_err || opc_err || short_err) |-> chk_valid);

  assert_short_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    short_err |-> (!arith_err && !opc_err));

  assert_early_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_vld && word_start && cnt != '0) |=> (short_err && chk_valid && cnt == CW'(1)));

  assert_stray_nibble_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && nib_vld && !word_start) |=>
      (cnt == '0 && $stable({chk_valid, arith_err, opc_err, short_err})));

  assert_gap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !nib_vld |=> ($stable(cnt) && $stable({chk_valid, arith_err, opc_err, short_err})));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(WORD_NIBS));
endmodule

bind mod15_bus_checker mod15_bus_checker_sva #(.WORD_NIBS(WORD_NIBS)) u_sva (.*);

// File: tb/tb_mod15_bus_checker.sv
module tb_mod15_bus_checker;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic word_start = 0, nib_vld = 0, word_instr = 0;
  logic [3:0] nib = 0;
  logic chk_valid, arith_err, opc_err, short_err;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  mod15_bus_checker dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit two_hot(logic [3:0] v);
    return $countones(v) == 2;
  endfunction

  function automatic bit exp_arith(logic [31:0] w, bit instr);
    int s = 0;
    for (int i = 0; i < (instr ? 5 : 8); i++) s += int'(w[4*i +: 4]);
    return !(s != 0 && s % 15 == 0);
  endfunction

  function automatic bit exp_opc(logic [31:0] w, bit instr);
    bit bad = 0;
    if (instr) for (int i = 5; i < 8; i++) if (!two_hot(w[4*i +: 4])) bad = 1;
    return bad;
  endfunction

  function automatic logic [3:0] opc_code(int k);
    case (k % 6)
      0: return 4'h3; 1: return 4'h5; 2: return 4'h6;
      3: return 4'h9; 4: return 4'hA; default: return 4'hC;
    endcase
  endfunction

  function automatic logic [31:0] mk_operand(logic [27:0] x);
    return 32'(x) * 32'd15;
  endfunction

  function automatic logic [31:0] mk_instr(int a, int b, int c, logic [15:0] addr);
    int r = int'(addr) % 15;
    logic [3:0] chk = (r == 0) ? 4'hF : 4'(15 - r);
    return {opc_code(a), opc_code(b), opc_code(c), chk, addr};
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic put(logic [3:0] n, logic st, logic v, logic ty);
    @(negedge clk);
    nib = n; word_start = st; nib_vld = v; word_instr = ty;
  endtask

  task automatic quiet();
    @(negedge clk);
    nib_vld = 0; word_start = 0; nib = 4'($urandom);
  endtask

  task automatic send_bytes(logic [31:0] w, bit instr, int k_lo, int k_hi, bit gaps);
    for (int k = k_lo; k <= k_hi; k++) begin
      int idx = instr ? ((k < 3) ? 5 + k : k - 3) : k;
      if (gaps && ($urandom % 4 == 0))
        put(4'($urandom), 1'($urandom), 1'b0, 1'($urandom));
      put(w[4*idx +: 4], k == 0, 1'b1, (k == 0) ? instr : 1'($urandom));
    end
  endtask

  task automatic verdict(string tag, logic [31:0] w, bit instr);
    quiet();
    check({tag, " R2 valid"}, chk_valid, 1'b1);
    check({tag, instr ? " R3 arith" : " R2 arith"}, arith_err, exp_arith(w, instr));
    check({tag, " R4 opc"}, opc_err, exp_opc(w, instr));
    check({tag, " R9 short"}, short_err, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 valid", chk_valid, 1'b0);
    check("R1 arith", arith_err, 1'b0);
    check("R1 opc", opc_err, 1'b0);
    check("R1 short", short_err, 1'b0);
    rst_n = 1;

    send_bytes(32'h0, 0, 0, 7, 0);             verdict("R5 zero operand", 32'h0, 0);
    check("R5 zero flagged", arith_err, 1'b1);
    send_bytes(32'hFFFF_FFFF, 0, 0, 7, 0);     verdict("R2 all ones", 32'hFFFF_FFFF, 0);
    w = {opc_code(0), opc_code(1), opc_code(2), 20'h0};
    send_bytes(w, 1, 0, 7, 0);                 verdict("R5 zero address", w, 1);
    w = {4'h7, opc_code(3), opc_code(4), 20'hF0000};
    send_bytes(w, 1, 0, 7, 0);                 verdict("R4 bad opcode", w, 1);
    check("R4 opcode flagged", opc_err, 1'b1);

    repeat (3) quiet();
    check("R6 hold valid", chk_valid, 1'b1);
    check("R6 hold opc", opc_err, 1'b1);
    put(4'h5, 1'b0, 1'b1, 1'b1);
    quiet();
    check("R8 stray valid", chk_valid, 1'b1);
    check("R8 stray opc", opc_err, 1'b1);
    put(4'h0, 1'b1, 1'b0, 1'b1);
    quiet();
    check("R7 start without valid", chk_valid, 1'b1);

    w = mk_operand(28'h123_4567);
    send_bytes(w, 0, 0, 0, 0);
    quiet();
    check("R6 drop on start", chk_valid, 1'b0);
    send_bytes(w, 0, 1, 3, 0);
    w = mk_instr(1, 2, 3, 16'hBEEF);
    send_bytes(w, 1, 0, 0, 0);
    quiet();
    check("R9 short flag", short_err, 1'b1);
    check("R9 short valid", chk_valid, 1'b1);
    check("R9 short arith", arith_err, 1'b0);
    check("R9 short opc", opc_err, 1'b0);
    send_bytes(w, 1, 1, 7, 0);                 verdict("R9 word after early start", w, 1);

    w = mk_operand(28'h0ABC_DEF);
    for (int k = 0; k < 8; k++) put(w[4*k +: 4], k == 0, 1'b1, k != 0);
    verdict("R10 type ignored mid word", w, 0);

    for (int t = 0; t < 400; t++) begin
      bit instr = 1'($urandom);
      w = instr ? mk_instr(int'($urandom % 6), int'($urandom % 6), int'($urandom % 6), 16'($urandom))
                : mk_operand(28'($urandom));
      if ($urandom % 3 == 0) w[$urandom % 32] ^= 1'b1;
      send_bytes(w, instr, 0, 7, 1);
      verdict("R10 random", w, instr);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule